// File: doc/BRIEF.md
# Timestamp Counter with Offset Reload

This block keeps a free-running timestamp for a message controller. A counter, `CNT_W` bits wide (16 by default), advances by one on every clock cycle where the count-enable tick is high. Three events restart it: the counter passes its top value, the counter reaches a programmed compare value, or an external identifier-match pulse arrives. On a restart the counter does not go to zero. It loads a software-programmed local offset instead.

Software reaches the block through a simple register port with a write strobe, an address and write data. Read data comes back one cycle after the address is presented. The counter, the compare value and the local offset can all be read and written. Two sticky status flags record overflow and compare match, and each one drives a level interrupt output. A status write cannot change the flags. A flag clears only when software writes a one to the matching bit of a separate interrupt-clear register.

The register map is as follows. Address 0 is the counter. Address 1 is the compare value. Address 2 is the local offset. Address 3 is the read-only status. Address 4 is the write-one-to-clear interrupt register, and it reads back the same flags. In both flag registers, bit 0 is overflow and bit 1 is compare match.

Top module: `tstamp_timer`

## Requirements
- R1: After a synchronous reset, the following all read as zero: counter, compare value, offset, both flags, both interrupt outputs and `reg_rdata`.
- R2: When no write, identifier match, overflow or compare match is involved, the counter goes up by exactly one on a cycle with `tick` high and holds its value on a cycle with `tick` low.
- R3: Take a cycle with `tick` high and a nonzero compare value equal to the counter. The compare-match flag (status bit 1) sets, and the next counter value is the local offset, with no cycle spent at zero.
- R4: A compare value of zero never sets the compare-match flag, even while the counter steps through zero. In that case the counter just increments.
- R5: On a cycle with `tick` high and the counter at its all-ones value, the overflow flag (status bit 0) sets and the next counter value is the local offset.
- R6: An `id_match` pulse loads the local offset into the counter on the next clock and leaves both flags unchanged. It takes priority over counting and over the overflow and compare events in that cycle.
- R7: A write to address 0 loads the counter on the next clock. It takes priority over `id_match` and counting in that cycle.
- R8: Writes to the status register at address 3 have no effect on either flag.
- R9: Writing to address 4 clears the flags whose bits are one in the write data (bit 0 overflow, bit 1 compare). Flags whose bits are zero keep their value.
- R10: If a flag's set event and a write-one-to-clear of that flag fall in the same cycle, the flag ends up set.
- R11: `irq_ovf` and `irq_cmp` are high on every cycle where the matching flag is set.
- R12: `reg_rdata` shows, one cycle after `reg_addr` is presented, the value the addressed register held before that clock. The compare and offset registers read back what was written to them. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable for the current cycle |
| id_match | input | 1 | Identifier-match pulse that restarts the counter from the offset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Registered read data |
| irq_ovf | output | 1 | Level interrupt, overflow flag |
| irq_cmp | output | 1 | Level interrupt, compare-match flag |

## Verification
Every result of this block appears exactly one clock after its cause. A counter load, reload or increment becomes visible by reading address 0 in the cycle after it takes effect. A flag set or clear appears on `irq_ovf` and `irq_cmp` right after the edge that samples the event. `reg_rdata` reflects the register state from before the edge that captured the address. The bench drives each stimulus at the falling edge and updates its reference model once per rising edge, using the old model state for the read value. It compares all three outputs 2 ns after that rising edge, so every expected value is checked in the cycle where it first becomes due.

// File: rtl/tstamp_pkg.sv
package tstamp_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_COUNT   = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_COMPARE = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_OFFSET  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STATUS  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_IRQCLR  = 3'd4;

  localparam int N_FLAGS  = 2;
  localparam int FLAG_OVF = 0;
  localparam int FLAG_CMP = 1;
endpackage

// File: rtl/tstamp_counter.sv
module tstamp_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         id_match,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] cmp_val,
  input  logic [W-1:0] ofs_val,
  output logic [W-1:0] cnt,
  output logic         ovf_evt,
  output logic         cmp_evt
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] cnt_q;
  logic         adv;

  // Counting proceeds only when neither a load nor an identifier match
  // takes the cycle; the restart events are only meaningful then.
  always_comb begin
    adv     = tick && !load && !id_match;
    ovf_evt = adv && (cnt_q == CNT_MAX);
    cmp_evt = adv && (cmp_val != '0) && (cnt_q == cmp_val);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (id_match || ovf_evt || cmp_evt) begin
      cnt_q <= ofs_val;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/tstamp_flags.sv
module tstamp_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] flag_q;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
      end else if (set_evt[i]) begin
        flag_q[i] <= 1'b1;
      end else if (clr_wr && clr_mask[i]) begin
        flag_q[i] <= 1'b0;
      end
    end
  end

  assign flags = flag_q;
endmodule

// File: rtl/tstamp_timer.sv
module tstamp_timer #(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          id_match,
  input  logic                          reg_wr,
  input  logic [tstamp_pkg::ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]              reg_wdata,
  output logic [CNT_W-1:0]              reg_rdata,
  output logic                          irq_ovf,
  output logic                          irq_cmp
);
  import tstamp_pkg::*;

  localparam int NF = N_FLAGS;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0] ofs_q;
  logic [NF-1:0]    flags;
  logic [NF-1:0]    set_evt;
  logic             ovf_evt;
  logic             cmp_evt;
  logic             wr_cnt;
  logic             wr_clr;
  logic [CNT_W-1:0] flag_word;

  assign wr_cnt = reg_wr && (reg_addr == ADR_COUNT);
  assign wr_clr = reg_wr && (reg_addr == ADR_IRQCLR);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      ofs_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADR_COMPARE) cmp_q <= reg_wdata;
      if (reg_addr == ADR_OFFSET)  ofs_q <= reg_wdata;
    end
  end

  tstamp_counter #(.W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .id_match (id_match),
    .load     (wr_cnt),
    .load_val (reg_wdata),
    .cmp_val  (cmp_q),
    .ofs_val  (ofs_q),
    .cnt      (cnt_q),
    .ovf_evt  (ovf_evt),
    .cmp_evt  (cmp_evt)
  );

  always_comb begin
    set_evt           = '0;
    set_evt[FLAG_OVF] = ovf_evt;
    set_evt[FLAG_CMP] = cmp_evt;
  end

  tstamp_flags #(.N(NF)) flg_i (
    .clk      (clk),
    .rst      (rst),
    .set_evt  (set_evt),
    .clr_wr   (wr_clr),
    .clr_mask (reg_wdata[NF-1:0]),
    .flags    (flags)
  );

  assign flag_word = {{(CNT_W-NF){1'b0}}, flags};

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        ADR_COUNT:   reg_rdata <= cnt_q;
        ADR_COMPARE: reg_rdata <= cmp_q;
        ADR_OFFSET:  reg_rdata <= ofs_q;
        ADR_STATUS:  reg_rdata <= flag_word;
        ADR_IRQCLR:  reg_rdata <= flag_word;
        default:     reg_rdata <= '0;
      endcase
    end
  end

  assign irq_ovf = flags[FLAG_OVF];
  assign irq_cmp = flags[FLAG_CMP];
endmodule

// File: rtl/tstamp_timer_chk.sv
module tstamp_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             id_match,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [CNT_W-1:0] reg_wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_val,
  input logic [CNT_W-1:0] ofs_val,
  input logic             irq_ovf,
  input logic             irq_cmp
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic wr_cnt, adv;
  assign wr_cnt = reg_wr && (reg_addr == 3'd0);
  assign adv    = tick && !wr_cnt && !id_match;

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    adv && (cnt != TOP) && !((cmp_val != '0) && (cnt == cmp_val))
      |=> cnt == $past(cnt) + 1'b1);

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick && !wr_cnt && !id_match |=> $stable(cnt));

  // R3
  cmp_match_chk: assert property (@(posedge clk) disable iff (rst)
    adv && (cmp_val != '0) && (cnt == cmp_val)
      |=> irq_cmp && (cnt == $past(ofs_val)));

  // R4
  cmp_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_cmp) |-> $past(cmp_val) != '0);

  // R5
  ovf_reload_chk: assert property (@(posedge clk) disable iff (rst)
    adv && (cnt == TOP) |=> irq_ovf && (cnt == $past(ofs_val)));

  // R6
  id_reload_chk: assert property (@(posedge clk) disable iff (rst)
    id_match && !wr_cnt |=> cnt == $past(ofs_val));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt |=> cnt == $past(reg_wdata));

  // R9
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && (reg_addr == 3'd4) && reg_wdata[0] && !(adv && (cnt == TOP))
      |=> !irq_ovf);

  // R8
  status_wr_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr && (reg_addr == 3'd3) && irq_ovf |=> irq_ovf);
endmodule

bind tstamp_timer tstamp_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .id_match  (id_match),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .cnt       (cnt_q),
  .cmp_val   (cmp_q),
  .ofs_val   (ofs_q),
  .irq_ovf   (irq_ovf),
  .irq_cmp   (irq_cmp)
);

// File: tb/tstamp_timer_tb.sv
module tstamp_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        tick, id_match, reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        irq_ovf, irq_cmp;

  always #4 clk = ~clk;

  tstamp_timer #(.CNT_W(16)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .id_match(id_match),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_ovf(irq_ovf), .irq_cmp(irq_cmp)
  );

  int total = 0;
  int bad   = 0;

  logic [15:0] m_cnt, m_cmp, m_ofs;
  logic        m_ovf, m_cmpf;

  function automatic logic [15:0] f_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt;
      3'd1: return m_cmp;
      3'd2: return m_ofs;
      3'd3, 3'd4: return {14'd0, m_cmpf, m_ovf};
      default: return 16'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wr, input logic [2:0] a, input logic [15:0] d,
                      input bit tk, input bit idm, input string tag);
    logic [15:0] exp_rd, nxt;
    bit adv, ov, cm, clr;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; tick = tk; id_match = idm;
    exp_rd = f_read(a);
    adv = tk && !(wr && a == 3'd0) && !idm;
    ov  = adv && (m_cnt == 16'hFFFF);
    cm  = adv && (m_cmp != 16'd0) && (m_cnt == m_cmp);
    if (wr && a == 3'd0)   nxt = d;
    else if (idm)          nxt = m_ofs;
    else if (ov || cm)     nxt = m_ofs;
    else if (tk)           nxt = m_cnt + 16'd1;
    else                   nxt = m_cnt;
    clr = wr && (a == 3'd4);
    m_ovf  = ov || (m_ovf  && !(clr && d[0]));
    m_cmpf = cm || (m_cmpf && !(clr && d[1]));
    m_cnt  = nxt;
    if (wr && a == 3'd1) m_cmp = d;
    if (wr && a == 3'd2) m_ofs = d;
    @(posedge clk);
    #2;
    chk({tag, " rdata"}, reg_rdata, exp_rd);
    chk({tag, " irq_ovf R11"}, {15'd0, irq_ovf}, {15'd0, m_ovf});
    chk({tag, " irq_cmp R11"}, {15'd0, irq_cmp}, {15'd0, m_cmpf});
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1'b0, a, 16'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic wrr(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(8 * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd11);
    rst = 1'b1; tick = 0; id_match = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_cnt = 0; m_cmp = 0; m_ofs = 0; m_ovf = 0; m_cmpf = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 rdata after reset", reg_rdata, 16'd0);
    chk("R1 irq after reset", {14'd0, irq_cmp, irq_ovf}, 16'd0);
    for (int a = 0; a < 5; a++) rd(3'(a), "R1 reset value");

    // R12 register readback
    wrr(3'd1, 16'h1234, "R12 write compare");
    rd(3'd1, "R12 read compare");
    wrr(3'd2, 16'h0100, "R12 write offset");
    rd(3'd2, "R12 read offset");
    rd(3'd6, "R12 unmapped");

    // R2 hold and increment
    wrr(3'd0, 16'h0005, "R7 load counter");
    rd(3'd0, "R2 hold");
    rd(3'd0, "R2 hold");
    step(0, 3'd0, 0, 1, 0, "R2 tick");
    step(0, 3'd0, 0, 1, 0, "R2 tick");
    rd(3'd0, "R2 after ticks");

    // R3 compare match reloads offset
    wrr(3'd1, 16'h0010, "R3 set compare");
    wrr(3'd0, 16'h000E, "R3 preload");
    for (int i = 0; i < 3; i++) step(0, 3'd0, 0, 1, 0, "R3 approach match");
    rd(3'd0, "R3 reloaded offset");
    rd(3'd3, "R3 status bit1");
    rd(3'd3, "R11 level held");

    // R8 status write ignored
    wrr(3'd3, 16'h0000, "R8 status write");
    rd(3'd3, "R8 flags unchanged");

    // R5 overflow reload
    wrr(3'd0, 16'hFFFE, "R5 preload");
    step(0, 3'd0, 0, 1, 0, "R5 tick");
    step(0, 3'd0, 0, 1, 0, "R5 wrap");
    rd(3'd0, "R5 reloaded offset");
    rd(3'd4, "R5 both flags");

    // R9 selective clear
    wrr(3'd4, 16'h0001, "R9 clear ovf only");
    rd(3'd4, "R9 cmp kept");
    wrr(3'd4, 16'h0002, "R9 clear cmp");
    rd(3'd3, "R9 all clear");

    // R10 set beats clear
    wrr(3'd0, 16'h0010, "R10 preload at compare");
    step(1, 3'd4, 16'h0003, 1, 0, "R10 set and clear together");
    rd(3'd3, "R10 cmp flag stays");
    wrr(3'd4, 16'h0003, "R10 cleanup");

    // R4 zero compare never matches
    wrr(3'd1, 16'h0000, "R4 compare zero");
    wrr(3'd2, 16'h0000, "R4 offset zero");
    wrr(3'd0, 16'hFFFF, "R4 preload");
    for (int i = 0; i < 4; i++) step(0, 3'd3, 0, 1, 0, "R4 step through zero");
    rd(3'd0, "R4 counter");
    wrr(3'd4, 16'h0001, "R4 cleanup");

    // R6 identifier match
    wrr(3'd2, 16'h0040, "R6 offset");
    wrr(3'd0, 16'hFFFF, "R6 preload at top");
    step(0, 3'd0, 0, 1, 1, "R6 id beats tick");
    rd(3'd0, "R6 counter at offset");
    rd(3'd3, "R6 no flags");

    // R7 write beats identifier match
    step(1, 3'd0, 16'h0777, 1, 1, "R7 write beats id");
    rd(3'd0, "R7 counter loaded");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit wr, tk, idm;
      logic [2:0] a;
      logic [15:0] d;
      wr  = ($urandom_range(0, 99) < 20);
      tk  = ($urandom_range(0, 99) < 70);
      idm = ($urandom_range(0, 99) < 3);
      a   = 3'($urandom_range(0, 5));
      case (a)
        3'd0: d = ($urandom_range(0, 3) == 0) ? 16'($urandom_range(16'hFFF0, 16'hFFFF))
                                              : 16'($urandom_range(0, 40));
        3'd1: d = 16'($urandom_range(0, 40));
        3'd2: d = 16'($urandom_range(0, 20));
        default: d = 16'($urandom_range(0, 3));
      endcase
      step(wr, a, d, tk, idm, "random R2/R3/R5/R9");
    end

    @(negedge clk);
    reg_wr = 0; tick = 0; id_match = 0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule